// File: doc/BRIEF.md
# Host Write Port with Transmit-FIFO Bypass

This block is the write-side front end for an asynchronous 16-bit host bus. The host drives an active-low chip-select and an active-low write strobe, a two-bit word address, a FIFO-select sideband and a data word. All of these are sampled on a fast internal clock through a synchroniser of equal depth, so the strobes, the address and the data stay aligned. A write cycle exists only while both strobes are low. The strobes may fall and rise in either order.

At the start of each cycle the block latches the word address and the FIFO-select bit. At the end of the cycle it takes the data word sampled just before the end. If FIFO-select was high, the word goes into a small transmit FIFO and the address plays no part. Otherwise the block emits a one-clock register-write pulse carrying the latched address and the word. The FIFO drains through a valid/ready handshake and reports its fill level.

Two sticky flags report host misbehaviour. The first flags a FIFO-bound write that arrives while the FIFO is full. The second flags a cycle whose asserted time, whose preceding idle gap, or whose total period is shorter than a programmable minimum counted in sampling clocks. One clear input resets both flags.

Top module: `hwp_top`

## Requirements
- R1: A write happens only when chip-select and write strobe are low together. Either strobe held low alone produces no register pulse and no FIFO entry.
- R2: The strobes may be asserted in either order and released in either order. A cycle ends when the first strobe rises, and each cycle yields exactly one write.
- R3: If fifo_sel is 1 at cycle start, the word enters the transmit FIFO whatever the address is. If it is 0, the word becomes a register write and the FIFO is unchanged.
- R4: The address and fifo_sel are latched on the first sample in which both strobes are low. Later changes within the same cycle are ignored.
- R5: The written word is the data sampled one clock before the end of the cycle. A data change that coincides with strobe release is not taken.
- R6: A register write is a reg_wr_stb pulse exactly one clock wide, with reg_wr_addr and reg_wr_data valid in that clock. It appears within 6 clocks of the cycle end.
- R7: The transmit FIFO holds FIFO_DEPTH (16) words in arrival order. tx_valid is 1 while tx_level is non-zero, and a word is removed on each clock in which both tx_valid and tx_ready are 1.
- R8: A FIFO-bound write that arrives while the FIFO holds 16 words, with no pop in the same clock, is dropped and sets ovf_flag. ovf_flag stays 1 until flag_clr is pulsed.
- R9: tmg_flag is set when a cycle's asserted time is below MIN_ACT_CLK samples. It stays set until flag_clr is pulsed, and legal cycles leave it at 0.
- R10: tmg_flag is set when the idle gap before a cycle, measured from the end of the previous cycle, is below MIN_GAP_CLK samples. The first cycle after reset is exempt.
- R11: tmg_flag is set when the previous gap plus the asserted time of a cycle is below MIN_CYC_CLK samples, even if each part alone is legal.
- R12: After reset, reg_wr_stb, tx_valid, tx_level, ovf_flag and tmg_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| host_cs_n | input | 1 | Host chip-select, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_addr | input | 2 | Host word address |
| host_fifo_sel | input | 1 | 1 routes the write to the transmit FIFO |
| host_data | input | 16 | Host write data |
| reg_wr_stb | output | 1 | One-clock register-write pulse |
| reg_wr_addr | output | 2 | Register word address |
| reg_wr_data | output | 16 | Register write data |
| tx_valid | output | 1 | FIFO head word is valid |
| tx_ready | input | 1 | Downstream accepts the head word |
| tx_data | output | 16 | FIFO head word |
| tx_level | output | 5 | Words held in the FIFO |
| flag_clr | input | 1 | Clears ovf_flag and tmg_flag |
| ovf_flag | output | 1 | Sticky FIFO overflow flag |
| tmg_flag | output | 1 | Sticky timing-violation flag |

## Verification
Register writes are driven with every mix of strobe order at both the start and the end of a cycle. This shows that the framer uses the AND of the two strobes and not either strobe alone. Cycles in which the address, fifo_sel and data change in the middle, or exactly at the release, show start-time capture of the routing fields apart from end-time capture of the word. FIFO-bound writes are run with mixed addresses, up to and beyond a full FIFO, to tell address bypass, ordering and drop-on-full apart. The timing tests break the asserted time, the gap and the total period one at a time, so that each limit is shown to trip the flag on its own.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
    localparam int unsigned HWP_DATA_W     = 16;
    localparam int unsigned HWP_ADDR_W     = 2;
    localparam int unsigned HWP_FIFO_DEPTH = 16;
    localparam int unsigned HWP_SYNC_STG   = 2;

    typedef enum logic {
        ROUTE_REG  = 1'b0,
        ROUTE_FIFO = 1'b1
    } route_e;
endpackage

// File: rtl/hwp_sync.sv
module hwp_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hwp_framer.sv
module hwp_framer
    import hwp_pkg::*;
#(
    parameter int unsigned DATA_W      = HWP_DATA_W,
    parameter int unsigned ADDR_W      = HWP_ADDR_W,
    parameter int unsigned MIN_ACT_CLK = 3,
    parameter int unsigned MIN_GAP_CLK = 1,
    parameter int unsigned MIN_CYC_CLK = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              wr_n_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              sel_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              flag_clr,
    output logic              reg_stb,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              push,
    output logic [DATA_W-1:0] wdata,
    output logic              tmg_flag
);
    localparam int unsigned LIM_AG  = (MIN_ACT_CLK > MIN_GAP_CLK) ? MIN_ACT_CLK : MIN_GAP_CLK;
    localparam int unsigned LIM_MAX = (LIM_AG > MIN_CYC_CLK) ? LIM_AG : MIN_CYC_CLK;
    localparam int unsigned CW      = $clog2(LIM_MAX + 1) + 1;
    localparam logic [CW-1:0] CNT_SAT = '1;
    localparam logic [CW-1:0] ACT_LIM = CW'(MIN_ACT_CLK);
    localparam logic [CW-1:0] GAP_LIM = CW'(MIN_GAP_CLK);
    localparam logic [CW:0]   CYC_LIM = (CW+1)'(MIN_CYC_CLK);

    typedef struct packed {
        logic              cyc;
        logic              seen;
        logic [DATA_W-1:0] dprev;
        logic [ADDR_W-1:0] addr;
        route_e            route;
        logic [CW-1:0]     act_cnt;
        logic [CW-1:0]     gap_cnt;
        logic [CW-1:0]     last_gap;
        logic              tmg;
        logic              reg_stb;
        logic              push;
        logic [ADDR_W-1:0] out_addr;
        logic [DATA_W-1:0] out_data;
    } frm_state_t;

    frm_state_t st_d, st_q;
    logic       cyc_now, cyc_start, cyc_stop;
    logic [CW:0] period;

    always_comb begin
        st_d      = st_q;
        cyc_now   = !cs_n_s && !wr_n_s;
        cyc_start = cyc_now && !st_q.cyc;
        cyc_stop  = !cyc_now && st_q.cyc;
        period    = {1'b0, st_q.act_cnt} + {1'b0, st_q.last_gap};

        st_d.cyc     = cyc_now;
        st_d.dprev   = data_s;
        st_d.reg_stb = 1'b0;
        st_d.push    = 1'b0;
        if (flag_clr) st_d.tmg = 1'b0;

        if (cyc_start) begin
            st_d.addr     = addr_s;
            st_d.route    = route_e'(sel_s);
            st_d.act_cnt  = CW'(1);
            st_d.last_gap = st_q.gap_cnt;
            if (st_q.seen && st_q.gap_cnt < GAP_LIM) st_d.tmg = 1'b1;
        end else if (cyc_now) begin
            if (st_q.act_cnt != CNT_SAT) st_d.act_cnt = st_q.act_cnt + CW'(1);
        end

        if (cyc_stop) begin
            if (st_q.act_cnt < ACT_LIM) st_d.tmg = 1'b1;
            if (st_q.seen && period < CYC_LIM) st_d.tmg = 1'b1;
            st_d.seen     = 1'b1;
            st_d.gap_cnt  = CW'(1);
            st_d.out_data = st_q.dprev;
            st_d.out_addr = st_q.addr;
            if (st_q.route == ROUTE_FIFO) st_d.push    = 1'b1;
            else                          st_d.reg_stb = 1'b1;
        end else if (!cyc_now) begin
            if (st_q.gap_cnt != CNT_SAT) st_d.gap_cnt = st_q.gap_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_stb  = st_q.reg_stb;
    assign reg_addr = st_q.out_addr;
    assign push     = st_q.push;
    assign wdata    = st_q.out_data;
    assign tmg_flag = st_q.tmg;

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_stb |=> !reg_stb);                                          // R6
    AST_WRITE_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_stb || push) |-> $past(st_q.cyc));                         // R1
    AST_TMG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmg_flag && !flag_clr) |=> tmg_flag);                          // R9
    AST_ROUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cyc && cyc_now) |=> $stable(st_q.route));                 // R4
endmodule

// File: rtl/hwp_txfifo.sv
module hwp_txfifo
    import hwp_pkg::*;
#(
    parameter int unsigned DATA_W = HWP_DATA_W,
    parameter int unsigned DEPTH  = HWP_FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_ready,
    input  logic              flag_clr,
    output logic              valid,
    output logic [DATA_W-1:0] head,
    output logic [$clog2(DEPTH):0] level,
    output logic              ovf
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LW = $clog2(DEPTH) + 1;
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] rd_ptr;
        logic [LW-1:0] level;
        logic          ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic full, pop, wr_en;

    always_comb begin
        st_d  = st_q;
        full  = (st_q.level == FULL_LVL);
        pop   = (st_q.level != '0) && pop_ready;
        wr_en = push && (!full || pop);
        if (flag_clr) st_d.ovf = 1'b0;
        if (push && full && !pop) st_d.ovf = 1'b1;
        if (wr_en) st_d.wr_ptr = (st_q.wr_ptr == LAST_IDX) ? '0 : st_q.wr_ptr + PW'(1);
        if (pop)   st_d.rd_ptr = (st_q.rd_ptr == LAST_IDX) ? '0 : st_q.rd_ptr + PW'(1);
        case ({wr_en, pop})
            2'b10:   st_d.level = st_q.level + LW'(1);
            2'b01:   st_d.level = st_q.level - LW'(1);
            default: st_d.level = st_q.level;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[st_q.wr_ptr] <= push_data;
    end

    assign valid = (st_q.level != '0);
    assign head  = mem[st_q.rd_ptr];
    assign level = st_q.level;
    assign ovf   = st_q.ovf;

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_LVL);                                             // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop_ready) |=> $stable(level));               // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !flag_clr) |=> ovf);                                    // R8
    AST_POP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && pop_ready && !push) |=> (level == $past(level) - LW'(1))); // R7
endmodule

// File: rtl/hwp_top.sv
module hwp_top
    import hwp_pkg::*;
#(
    parameter int unsigned DATA_W      = HWP_DATA_W,
    parameter int unsigned ADDR_W      = HWP_ADDR_W,
    parameter int unsigned FIFO_DEPTH  = HWP_FIFO_DEPTH,
    parameter int unsigned SYNC_STAGES = HWP_SYNC_STG,
    parameter int unsigned MIN_ACT_CLK = 3,
    parameter int unsigned MIN_GAP_CLK = 1,
    parameter int unsigned MIN_CYC_CLK = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_cs_n,
    input  logic                        host_wr_n,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic                        host_fifo_sel,
    input  logic [DATA_W-1:0]           host_data,
    output logic                        reg_wr_stb,
    output logic [ADDR_W-1:0]           reg_wr_addr,
    output logic [DATA_W-1:0]           reg_wr_data,
    output logic                        tx_valid,
    input  logic                        tx_ready,
    output logic [DATA_W-1:0]           tx_data,
    output logic [$clog2(FIFO_DEPTH):0] tx_level,
    input  logic                        flag_clr,
    output logic                        ovf_flag,
    output logic                        tmg_flag
);
    localparam int unsigned BUS_W = 3 + ADDR_W + DATA_W;
    localparam logic [BUS_W-1:0] BUS_RST = {2'b11, {(BUS_W-2){1'b0}}};

    logic [BUS_W-1:0]  bus_s;
    logic              cs_n_s, wr_n_s, sel_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic              push;
    logic [DATA_W-1:0] wdata;

    hwp_sync #(
        .WIDTH   (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_RST)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_cs_n, host_wr_n, host_fifo_sel, host_addr, host_data}),
        .sync_o  (bus_s)
    );

    assign {cs_n_s, wr_n_s, sel_s, addr_s, data_s} = bus_s;

    hwp_framer #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .MIN_ACT_CLK (MIN_ACT_CLK),
        .MIN_GAP_CLK (MIN_GAP_CLK),
        .MIN_CYC_CLK (MIN_CYC_CLK)
    ) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_n_s),
        .wr_n_s   (wr_n_s),
        .addr_s   (addr_s),
        .sel_s    (sel_s),
        .data_s   (data_s),
        .flag_clr (flag_clr),
        .reg_stb  (reg_wr_stb),
        .reg_addr (reg_wr_addr),
        .push     (push),
        .wdata    (wdata),
        .tmg_flag (tmg_flag)
    );

    assign reg_wr_data = wdata;

    hwp_txfifo #(
        .DATA_W (DATA_W),
        .DEPTH  (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wdata),
        .pop_ready (tx_ready),
        .flag_clr  (flag_clr),
        .valid     (tx_valid),
        .head      (tx_data),
        .level     (tx_level),
        .ovf       (ovf_flag)
    );
endmodule

// File: tb/hwp_top_test.sv
module hwp_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, fsel = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] data = '0;
    logic        tx_ready = 1'b0, flag_clr = 1'b0;
    logic        reg_wr_stb, tx_valid, ovf_flag, tmg_flag;
    logic [1:0]  reg_wr_addr;
    logic [15:0] reg_wr_data, tx_data;
    logic [4:0]  tx_level;

    int n_chk = 0, n_bad = 0;
    int reg_cnt = 0, wide_cnt = 0;
    logic [1:0]  last_addr = '0;
    logic [15:0] last_data = '0;
    logic        stb_prev = 1'b0;

    always #5 clk = ~clk;

    hwp_top #(.MIN_ACT_CLK(3), .MIN_GAP_CLK(3), .MIN_CYC_CLK(8)) uut (
        .clk(clk), .rst_n(rst_n), .host_cs_n(cs_n), .host_wr_n(wr_n),
        .host_addr(addr), .host_fifo_sel(fsel), .host_data(data),
        .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_level(tx_level),
        .flag_clr(flag_clr), .ovf_flag(ovf_flag), .tmg_flag(tmg_flag));

    always @(negedge clk) begin
        if (reg_wr_stb) begin
            reg_cnt++;
            last_addr = reg_wr_addr;
            last_data = reg_wr_data;
            if (stb_prev) wide_cnt++;
        end
        stb_prev = reg_wr_stb;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // smode: 0 both fall, 1 cs first, 2 wr first; emode: 0 both rise, 1 wr first, 2 cs first
    task automatic host_write(input bit sel, input logic [1:0] a, input logic [15:0] d,
                              input int act, input int gap, input int smode, input int emode);
        fsel = sel; addr = a; data = d;
        if (smode == 1) begin cs_n = 1'b0; clocks(1); end
        if (smode == 2) begin wr_n = 1'b0; clocks(1); end
        cs_n = 1'b0; wr_n = 1'b0;
        clocks(act);
        data = ~d;
        if (emode == 1 && gap > 1)      wr_n = 1'b1;
        else if (emode == 2 && gap > 1) cs_n = 1'b1;
        else begin cs_n = 1'b1; wr_n = 1'b1; end
        clocks(1);
        cs_n = 1'b1; wr_n = 1'b1;
        clocks(gap - 1);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; clocks(1); flag_clr = 1'b0; clocks(1);
    endtask

    task automatic t_reset();
        check(reg_wr_stb == 1'b0, "R12 reg_wr_stb", reg_wr_stb, 0);
        check(tx_valid == 1'b0, "R12 tx_valid", tx_valid, 0);
        check(tx_level == 5'd0, "R12 tx_level", tx_level, 0);
        check(ovf_flag == 1'b0, "R12 ovf_flag", ovf_flag, 0);
        check(tmg_flag == 1'b0, "R12 tmg_flag", tmg_flag, 0);
    endtask

    task automatic t_orders();
        int base;
        base = reg_cnt;
        host_write(1'b0, 2'd1, 16'h1111, 5, 8, 0, 0);
        check(reg_cnt == base + 1, "R2 both/both count", reg_cnt, base + 1);
        check(last_addr == 2'd1 && last_data == 16'h1111, "R6 addr/data", last_data, 16'h1111);
        host_write(1'b0, 2'd2, 16'h2222, 5, 8, 1, 1);
        check(reg_cnt == base + 2, "R2 cs-first/wr-first count", reg_cnt, base + 2);
        check(last_addr == 2'd2 && last_data == 16'h2222, "R2 data", last_data, 16'h2222);
        host_write(1'b0, 2'd3, 16'h3333, 5, 8, 2, 2);
        check(reg_cnt == base + 3, "R2 wr-first/cs-first count", reg_cnt, base + 3);
        check(last_addr == 2'd3 && last_data == 16'h3333, "R2 data", last_data, 16'h3333);
        host_write(1'b0, 2'd0, 16'hA5C3, 5, 8, 1, 2);
        check(reg_cnt == base + 4, "R2 cs-first/cs-first count", reg_cnt, base + 4);
        check(last_addr == 2'd0 && last_data == 16'hA5C3, "R3 reg route", last_data, 16'hA5C3);
        check(wide_cnt == 0, "R6 pulse width", wide_cnt, 0);
        check(tx_level == 5'd0, "R3 fifo untouched", tx_level, 0);
        pulse_clr();
        check(tmg_flag == 1'b0, "R9 legal cycles no flag", tmg_flag, 0);
    endtask

    task automatic t_single_strobe();
        int base;
        base = reg_cnt;
        fsel = 1'b1; data = 16'hDEAD;
        wr_n = 1'b0; clocks(6); wr_n = 1'b1; clocks(8);
        fsel = 1'b0;
        cs_n = 1'b0; clocks(6); cs_n = 1'b1; clocks(8);
        check(reg_cnt == base, "R1 single strobe no reg write", reg_cnt, base);
        check(tx_level == 5'd0, "R1 single strobe no fifo push", tx_level, 0);
    endtask

    task automatic t_capture();
        int base;
        base = reg_cnt;
        fsel = 1'b0; addr = 2'd2; data = 16'h0F0F;
        cs_n = 1'b0; wr_n = 1'b0;
        clocks(1);
        fsel = 1'b1; addr = 2'd1;
        clocks(2);
        data = 16'h7E57;
        clocks(3);
        data = 16'hBAD0; cs_n = 1'b1; wr_n = 1'b1;
        clocks(8);
        check(reg_cnt == base + 1, "R4 routed by start-time sel", reg_cnt, base + 1);
        check(last_addr == 2'd2, "R4 start-time addr", last_addr, 2);
        check(last_data == 16'h7E57, "R5 pre-end data", last_data, 16'h7E57);
        check(tx_level == 5'd0, "R4 late sel ignored", tx_level, 0);
    endtask

    task automatic t_fifo();
        int base;
        base = reg_cnt;
        host_write(1'b1, 2'd0, 16'h0101, 5, 8, 0, 0);
        host_write(1'b1, 2'd3, 16'h0202, 5, 8, 2, 1);
        host_write(1'b1, 2'd1, 16'h0303, 5, 8, 1, 2);
        check(tx_level == 5'd3, "R3 fifo level", tx_level, 3);
        check(reg_cnt == base, "R3 no reg write for fifo", reg_cnt, base);
        check(tx_valid == 1'b1, "R7 valid when non-empty", tx_valid, 1);
        for (int i = 1; i <= 3; i++) begin
            check(tx_data == 16'(i * 16'h0101), "R7 fifo order", tx_data, i * 16'h0101);
            tx_ready = 1'b1; clocks(1); tx_ready = 1'b0;
        end
        check(tx_level == 5'd0 && tx_valid == 1'b0, "R7 empty after pops", tx_level, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 17; i++) host_write(1'b1, 2'(i), 16'(16'h5000 + i), 4, 6, 0, 0);
        clocks(2);
        check(tx_level == 5'd16, "R7 full level", tx_level, 16);
        check(ovf_flag == 1'b1, "R8 overflow set", ovf_flag, 1);
        for (int i = 0; i < 16; i++) begin
            check(tx_data == 16'(16'h5000 + i), "R8 dropped word absent", tx_data, 16'h5000 + i);
            tx_ready = 1'b1; clocks(1); tx_ready = 1'b0;
        end
        check(tx_level == 5'd0, "R8 drained", tx_level, 0);
        check(ovf_flag == 1'b1, "R8 overflow sticky", ovf_flag, 1);
        pulse_clr();
        check(ovf_flag == 1'b0, "R8 overflow cleared", ovf_flag, 0);
    endtask

    task automatic t_timing();
        pulse_clr();
        host_write(1'b0, 2'd0, 16'h0001, 1, 8, 0, 0);
        check(tmg_flag == 1'b1, "R9 short active", tmg_flag, 1);
        pulse_clr();
        check(tmg_flag == 1'b0, "R9 flag cleared", tmg_flag, 0);
        host_write(1'b0, 2'd0, 16'h0002, 6, 1, 0, 0);
        host_write(1'b0, 2'd0, 16'h0003, 6, 8, 0, 0);
        check(tmg_flag == 1'b1, "R10 short gap", tmg_flag, 1);
        pulse_clr();
        host_write(1'b0, 2'd0, 16'h0004, 6, 3, 0, 0);
        host_write(1'b0, 2'd0, 16'h0005, 4, 8, 0, 0);
        check(tmg_flag == 1'b1, "R11 short period", tmg_flag, 1);
        pulse_clr();
        host_write(1'b0, 2'd0, 16'h0006, 3, 5, 0, 0);
        host_write(1'b0, 2'd0, 16'h0007, 3, 8, 0, 0);
        check(tmg_flag == 1'b0, "R11 period at limit legal", tmg_flag, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clocks(4);
        rst_n = 1'b1;
        clocks(3);
        t_reset();
        t_orders();
        t_single_strobe();
        t_capture();
        t_fifo();
        t_overflow();
        t_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule